// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the memory-mapped register front end of a multi-channel DMA controller. Software programs each channel through a private 16-byte window that holds a buffer address, an x-length, a y-length and a control word. Each channel also has a line-width register in a separate table. A write to a channel's address register launches that channel. At that moment the block copies the channel's programmed settings into the active configuration it drives to the data mover, and it pulses that channel's start line for one cycle.

A group of shared registers controls the running channels. One register reports which channels are running, and a write to it stops channels. A second register holds interrupt status and is cleared by writing ones. Interrupt enable and loop control each have a set address and a clear address. Each channel reports completion or loop-wrap events to the block on a per-channel input. The block records these events as status bits and combines the enabled ones into one interrupt line. Address generation and data movement happen outside this block.

Top module: `dma_regbank`

## Requirements
- R1: Channel n's address, x-length, y-length and control registers are at byte offsets n*0x10 + 0x0, 0x4, 0x8 and 0xC. Its width register is at 0x100 + n*4. Reads return the value last written. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R2: A write to channel n's address register raises `ch_start[n]` for exactly one cycle, starting in the cycle after the write, and no other start line rises. In that same cycle `ch_valid[n]` is 1 and `cfg_addr[n]` holds the written value.
- R3: Writes to a channel's x-length, y-length, width or control register leave that channel's `cfg_*` outputs unchanged. The new values reach the outputs only at the channel's next start.
- R4: At start, control bit 4 becomes `cfg_burst[n]` (burst mode) and control bit 5 becomes `cfg_dir[n]` (direction).
- R5: The running register at 0x140 reads back `ch_valid`. A write to it clears each channel whose bit is written as 1 and leaves the other channels unchanged.
- R6: A pulse on `ch_done[n]` sets status bit n. If channel n is not looping, the pulse also clears `ch_valid[n]`. If channel n is looping, `ch_valid[n]` stays set.
- R7: Status at 0x144 is cleared by writing ones: writing 1<<n clears only bit n. If an event arrives in the same cycle as the clear, the event wins and the bit stays set.
- R8: A write to 0x148 sets the enable bits written as 1. A write to 0x14C clears the enable bits written as 1. Other enable bits are left unchanged, and reads of 0x14C return 0.
- R9: `irq` is high exactly when some status bit and its enable bit are both set.
- R10: A write to 0x150 sets loop bits and a write to 0x154 clears them. Reads of 0x150 return the loop bits, and reads of 0x154 return 0. Channel n loops (`loop_on[n]`) only while both bit n and bit n+16 are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, one cycle after bus_rd |
| ch_done | input | NUM_CH | Per-channel completion or loop-wrap event |
| ch_start | output | NUM_CH | One-cycle launch pulse per channel |
| ch_valid | output | NUM_CH | Channel running |
| loop_on | output | NUM_CH | Channel in looping mode |
| cfg_addr | output | NUM_CH x DW | Active start address (word address) |
| cfg_xlen | output | NUM_CH x DW | Active x-length |
| cfg_ylen | output | NUM_CH x DW | Active y-length |
| cfg_width | output | NUM_CH x DW | Active line width |
| cfg_burst | output | NUM_CH | Active burst-mode select |
| cfg_dir | output | NUM_CH | Active direction select |
| irq | output | 1 | Combined interrupt |

## Verification
The two hardest cases to reach from the ports both involve a channel event landing at an awkward moment. The first is an event that arrives in the same clock as a software clear of the same status bit. The second is a completion on a looping channel that has been paused and then resumed. The bench reaches the first by driving `ch_done` and a status-clear write on the same falling edge. It reaches the second by stepping one channel through loop set, single-bit set, clear and set again, with a completion pulse between steps. After each step it reads `ch_valid` and the status register to confirm whether the channel should still be running. Every channel is also swept through program, launch, reprogram-without-launch and event, using register values computed from the channel number.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

  typedef enum logic [3:0] {
    RK_NONE, RK_ADDR, RK_XLEN, RK_YLEN, RK_CTRL, RK_WIDTH,
    RK_VALID, RK_STAT, RK_EN_SET, RK_EN_CLR, RK_LOOP_SET, RK_LOOP_CLR
  } reg_kind_e;

  localparam int unsigned WIN_END     = 32'h100;
  localparam int unsigned WIDTH_BASE  = 32'h100;
  localparam int unsigned WIDTH_END   = 32'h140;
  localparam int unsigned OFS_VALID   = 32'h140;
  localparam int unsigned OFS_STAT    = 32'h144;
  localparam int unsigned OFS_EN_SET  = 32'h148;
  localparam int unsigned OFS_EN_CLR  = 32'h14C;
  localparam int unsigned OFS_LP_SET  = 32'h150;
  localparam int unsigned OFS_LP_CLR  = 32'h154;
  localparam int unsigned BURST_BIT   = 4;
  localparam int unsigned DIR_BIT     = 5;
  localparam int unsigned LOOP_HI     = 16;

  // Both halves of the loop pair must be set for a channel to loop.
  function automatic logic [15:0] loop_pairs(input logic [31:0] lp);
    return lp[15:0] & lp[31:16];
  endfunction

  // Status update: events win over a write-one-to-clear in the same cycle.
  function automatic logic [31:0] w1c_next(input logic [31:0] cur,
                                           input logic [31:0] clr,
                                           input logic [31:0] ev);
    return (cur & ~clr) | ev;
  endfunction

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_regbank_pkg::*;
#(
  parameter int AW     = 12,
  parameter int NUM_CH = 16,
  parameter int CHW    = 4
) (
  input  logic [AW-1:0]  addr,
  output reg_kind_e      kind,
  output logic [CHW-1:0] ch
);

  always_comb begin
    kind = RK_NONE;
    ch   = '0;
    if (addr < AW'(WIN_END)) begin
      if (32'(addr[7:4]) < NUM_CH) begin
        ch = addr[4 +: CHW];
        case (addr[3:2])
          2'd0:    kind = RK_ADDR;
          2'd1:    kind = RK_XLEN;
          2'd2:    kind = RK_YLEN;
          default: kind = RK_CTRL;
        endcase
      end
    end else if (addr < AW'(WIDTH_END)) begin
      if (32'(addr[5:2]) < NUM_CH) begin
        ch   = addr[2 +: CHW];
        kind = RK_WIDTH;
      end
    end else begin
      case (addr)
        AW'(OFS_VALID):  kind = RK_VALID;
        AW'(OFS_STAT):   kind = RK_STAT;
        AW'(OFS_EN_SET): kind = RK_EN_SET;
        AW'(OFS_EN_CLR): kind = RK_EN_CLR;
        AW'(OFS_LP_SET): kind = RK_LOOP_SET;
        AW'(OFS_LP_CLR): kind = RK_LOOP_CLR;
        default:         kind = RK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DW     = 32,
  parameter int CHW    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  reg_kind_e                   kind,
  input  logic [CHW-1:0]              ch,
  input  logic [DW-1:0]               wdata,
  output logic [NUM_CH-1:0][DW-1:0]   sh_addr,
  output logic [NUM_CH-1:0][DW-1:0]   sh_xlen,
  output logic [NUM_CH-1:0][DW-1:0]   sh_ylen,
  output logic [NUM_CH-1:0][DW-1:0]   sh_ctrl,
  output logic [NUM_CH-1:0][DW-1:0]   sh_width,
  output logic [NUM_CH-1:0][DW-1:0]   cfg_addr,
  output logic [NUM_CH-1:0][DW-1:0]   cfg_xlen,
  output logic [NUM_CH-1:0][DW-1:0]   cfg_ylen,
  output logic [NUM_CH-1:0][DW-1:0]   cfg_width,
  output logic [NUM_CH-1:0]           cfg_burst,
  output logic [NUM_CH-1:0]           cfg_dir,
  output logic [NUM_CH-1:0]           start
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic          hit;
    logic [DW-1:0] a_q, x_q, y_q, c_q, w_q;
    logic [DW-1:0] act_a, act_x, act_y, act_w;
    logic          act_burst, act_dir, s_q;

    assign hit = wr && (ch == CHW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q <= '0; x_q <= '0; y_q <= '0; c_q <= '0; w_q <= '0;
        act_a <= '0; act_x <= '0; act_y <= '0; act_w <= '0;
        act_burst <= 1'b0; act_dir <= 1'b0; s_q <= 1'b0;
      end else begin
        s_q <= 1'b0;
        if (hit) begin
          case (kind)
            RK_ADDR: begin
              a_q       <= wdata;
              act_a     <= wdata;
              act_x     <= x_q;
              act_y     <= y_q;
              act_w     <= w_q;
              act_burst <= c_q[BURST_BIT];
              act_dir   <= c_q[DIR_BIT];
              s_q       <= 1'b1;
            end
            RK_XLEN:  x_q <= wdata;
            RK_YLEN:  y_q <= wdata;
            RK_CTRL:  c_q <= wdata;
            RK_WIDTH: w_q <= wdata;
            default: ;
          endcase
        end
      end
    end

    assign sh_addr[g]   = a_q;
    assign sh_xlen[g]   = x_q;
    assign sh_ylen[g]   = y_q;
    assign sh_ctrl[g]   = c_q;
    assign sh_width[g]  = w_q;
    assign cfg_addr[g]  = act_a;
    assign cfg_xlen[g]  = act_x;
    assign cfg_ylen[g]  = act_y;
    assign cfg_width[g] = act_w;
    assign cfg_burst[g] = act_burst;
    assign cfg_dir[g]   = act_dir;
    assign start[g]     = s_q;
  end

endmodule

// File: rtl/dma_shared_regs.sv
module dma_shared_regs
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_kind_e         kind,
  input  logic [DW-1:0]     wdata,
  input  logic [NUM_CH-1:0] launch,
  input  logic [NUM_CH-1:0] ch_done,
  output logic [NUM_CH-1:0] valid_q,
  output logic [NUM_CH-1:0] stat_q,
  output logic [NUM_CH-1:0] en_q,
  output logic [31:0]       loop_q,
  output logic [NUM_CH-1:0] loop_on
);

  localparam logic [31:0] CH_MASK   = 32'((64'd1 << NUM_CH) - 64'd1);
  localparam logic [31:0] LOOP_MASK = CH_MASK | (CH_MASK << LOOP_HI);

  logic [NUM_CH-1:0] wbits;
  logic [NUM_CH-1:0] stop_m, stat_clr, en_set, en_clr, end_ev;
  logic [31:0]       lp_set, lp_clr, stat_nx;
  logic [15:0]       pairs;

  assign wbits    = wdata[NUM_CH-1:0];
  assign stop_m   = (wr && kind == RK_VALID)  ? wbits : '0;
  assign stat_clr = (wr && kind == RK_STAT)   ? wbits : '0;
  assign en_set   = (wr && kind == RK_EN_SET) ? wbits : '0;
  assign en_clr   = (wr && kind == RK_EN_CLR) ? wbits : '0;
  assign lp_set   = (wr && kind == RK_LOOP_SET) ? (wdata[31:0] & LOOP_MASK) : '0;
  assign lp_clr   = (wr && kind == RK_LOOP_CLR) ? wdata[31:0] : '0;

  assign pairs    = loop_pairs(loop_q);
  assign loop_on  = pairs[NUM_CH-1:0];
  assign end_ev   = ch_done & ~loop_on;
  assign stat_nx  = w1c_next(32'(stat_q), 32'(stat_clr), 32'(ch_done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      stat_q  <= '0;
      en_q    <= '0;
      loop_q  <= '0;
    end else begin
      valid_q <= (valid_q & ~stop_m & ~end_ev) | launch;
      stat_q  <= stat_nx[NUM_CH-1:0];
      en_q    <= (en_q & ~en_clr) | en_set;
      loop_q  <= (loop_q & ~lp_clr) | lp_set;
    end
  end

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DW     = 32,
  parameter int AW     = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [AW-1:0]              bus_addr,
  input  logic [DW-1:0]              bus_wdata,
  output logic [DW-1:0]              bus_rdata,
  input  logic [NUM_CH-1:0]          ch_done,
  output logic [NUM_CH-1:0]          ch_start,
  output logic [NUM_CH-1:0]          ch_valid,
  output logic [NUM_CH-1:0]          loop_on,
  output logic [NUM_CH-1:0][DW-1:0]  cfg_addr,
  output logic [NUM_CH-1:0][DW-1:0]  cfg_xlen,
  output logic [NUM_CH-1:0][DW-1:0]  cfg_ylen,
  output logic [NUM_CH-1:0][DW-1:0]  cfg_width,
  output logic [NUM_CH-1:0]          cfg_burst,
  output logic [NUM_CH-1:0]          cfg_dir,
  output logic                       irq
);

  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  reg_kind_e                 kind;
  logic [CHW-1:0]            ch;
  logic [NUM_CH-1:0]         launch;
  logic [NUM_CH-1:0]         stat_q, en_q;
  logic [31:0]               loop_q;
  logic [NUM_CH-1:0][DW-1:0] sh_addr, sh_xlen, sh_ylen, sh_ctrl, sh_width;
  logic [DW-1:0]             rd_val;

  dma_reg_decode #(.AW(AW), .NUM_CH(NUM_CH), .CHW(CHW)) u_dec (
    .addr (bus_addr),
    .kind (kind),
    .ch   (ch)
  );

  assign launch = (bus_wr && kind == RK_ADDR) ? (NUM_CH'(1) << ch) : '0;

  dma_chan_regs #(.NUM_CH(NUM_CH), .DW(DW), .CHW(CHW)) u_chan (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .kind      (kind),
    .ch        (ch),
    .wdata     (bus_wdata),
    .sh_addr   (sh_addr),
    .sh_xlen   (sh_xlen),
    .sh_ylen   (sh_ylen),
    .sh_ctrl   (sh_ctrl),
    .sh_width  (sh_width),
    .cfg_addr  (cfg_addr),
    .cfg_xlen  (cfg_xlen),
    .cfg_ylen  (cfg_ylen),
    .cfg_width (cfg_width),
    .cfg_burst (cfg_burst),
    .cfg_dir   (cfg_dir),
    .start     (ch_start)
  );

  dma_shared_regs #(.NUM_CH(NUM_CH), .DW(DW)) u_shared (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .kind    (kind),
    .wdata   (bus_wdata),
    .launch  (launch),
    .ch_done (ch_done),
    .valid_q (ch_valid),
    .stat_q  (stat_q),
    .en_q    (en_q),
    .loop_q  (loop_q),
    .loop_on (loop_on)
  );

  assign irq = |(stat_q & en_q);

  always_comb begin
    case (kind)
      RK_ADDR:     rd_val = sh_addr[ch];
      RK_XLEN:     rd_val = sh_xlen[ch];
      RK_YLEN:     rd_val = sh_ylen[ch];
      RK_CTRL:     rd_val = sh_ctrl[ch];
      RK_WIDTH:    rd_val = sh_width[ch];
      RK_VALID:    rd_val = DW'(ch_valid);
      RK_STAT:     rd_val = DW'(stat_q);
      RK_EN_SET:   rd_val = DW'(en_q);
      RK_LOOP_SET: rd_val = DW'(loop_q);
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_val : '0;
  end

endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DW     = 32,
  parameter int AW     = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [AW-1:0]             bus_addr,
  input logic [DW-1:0]             bus_wdata,
  input logic [NUM_CH-1:0]         ch_done,
  input logic [NUM_CH-1:0]         ch_start,
  input logic [NUM_CH-1:0]         ch_valid,
  input logic [NUM_CH-1:0][DW-1:0] cfg_xlen,
  input logic [NUM_CH-1:0]         stat_q,
  input logic [NUM_CH-1:0]         en_q,
  input logic                      irq
);

  logic stat_wr, enclr_wr;
  assign stat_wr  = bus_wr && (bus_addr == AW'(OFS_STAT));
  assign enclr_wr = bus_wr && (bus_addr == AW'(OFS_EN_CLR));

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start)); // R2

  AST_START_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start & ~ch_valid) == '0); // R2

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start == '0) |-> $stable(cfg_xlen)); // R3

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_done != '0) |=> ((stat_q & $past(ch_done)) == $past(ch_done))); // R6

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && ch_done == '0) |=> ((stat_q & $past(bus_wdata[NUM_CH-1:0])) == '0)); // R7

  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    enclr_wr |=> ((en_q & $past(bus_wdata[NUM_CH-1:0])) == '0)); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq); // R9

endmodule

bind dma_regbank dma_regbank_chk #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ch_done   (ch_done),
  .ch_start  (ch_start),
  .ch_valid  (ch_valid),
  .cfg_xlen  (cfg_xlen),
  .stat_q    (stat_q),
  .en_q      (en_q),
  .irq       (irq)
);

// File: tb/dma_regbank_bench.sv
`timescale 1ns/100ps
module dma_regbank_bench;
  localparam int NCH = 16;
  localparam int DW  = 32;
  localparam int AW  = 12;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]           bus_addr = '0;
  logic [DW-1:0]           bus_wdata = '0;
  logic [DW-1:0]           bus_rdata;
  logic [NCH-1:0]          ch_done = '0;
  logic [NCH-1:0]          ch_start, ch_valid, loop_on, cfg_burst, cfg_dir;
  logic [NCH-1:0][DW-1:0]  cfg_addr, cfg_xlen, cfg_ylen, cfg_width;
  logic                    irq;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  dma_regbank #(.NUM_CH(NCH), .DW(DW), .AW(AW)) u_dma_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_done(ch_done), .ch_start(ch_start), .ch_valid(ch_valid),
    .loop_on(loop_on), .cfg_addr(cfg_addr), .cfg_xlen(cfg_xlen),
    .cfg_ylen(cfg_ylen), .cfg_width(cfg_width), .cfg_burst(cfg_burst),
    .cfg_dir(cfg_dir), .irq(irq)
  );

  function automatic logic [31:0] xl(int n); return 32'h1000 + 32'(n) * 3;  endfunction
  function automatic logic [31:0] yl(int n); return 32'h2000 + 32'(n) * 5;  endfunction
  function automatic logic [31:0] wd(int n); return 32'h40 + 32'(n);        endfunction
  function automatic logic [31:0] ct(int n); return 32'((n % 4) << 4) | 32'(n); endfunction
  function automatic logic [31:0] ad(int n); return 32'hA000_0000 + 32'(n) * 16; endfunction
  function automatic logic [AW-1:0] win(int n, int r); return AW'(n * 16 + r * 4); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk); ch_done = m;
    @(negedge clk); ch_done = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0]    r;
    logic [NCH-1:0] vm, sm, em;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset irq", 32'(irq), 0);
    chk("R5 reset valid", 32'(ch_valid), 0);
    chk("R2 reset start", 32'(ch_start), 0);
    rd(12'h144, r); chk("R7 reset status", r, 0);

    // Program, launch and reprogram every channel
    for (int n = 0; n < NCH; n++) begin
      wr(win(n, 1), xl(n)); wr(win(n, 2), yl(n));
      wr(win(n, 3), ct(n)); wr(AW'(12'h100 + n * 4), wd(n));
      rd(win(n, 1), r); chk("R1 xlen readback", r, xl(n));
      rd(win(n, 2), r); chk("R1 ylen readback", r, yl(n));
      rd(win(n, 3), r); chk("R1 ctrl readback", r, ct(n));
      rd(AW'(12'h100 + n * 4), r); chk("R1 width readback", r, wd(n));
      chk("R3 cfg before start", cfg_xlen[n], 0);
      wr(win(n, 0), ad(n));
      chk("R2 start pulse", 32'(ch_start), 32'(1) << n);
      chk("R2 valid at start", 32'(ch_valid[n]), 1);
      chk("R2 cfg addr", cfg_addr[n], ad(n));
      chk("R2 cfg xlen", cfg_xlen[n], xl(n));
      chk("R2 cfg ylen", cfg_ylen[n], yl(n));
      chk("R2 cfg width", cfg_width[n], wd(n));
      chk("R4 burst bit", 32'(cfg_burst[n]), 32'(ct(n) >> 4) & 1);
      chk("R4 dir bit", 32'(cfg_dir[n]), 32'(ct(n) >> 5) & 1);
      @(negedge clk);
      chk("R2 pulse one cycle", 32'(ch_start), 0);
      rd(win(n, 0), r); chk("R1 addr readback", r, ad(n));
      wr(win(n, 1), xl(n) ^ 32'hFFFF);
      chk("R3 cfg held after rewrite", cfg_xlen[n], xl(n));
      rd(win(n, 1), r); chk("R1 shadow updated", r, xl(n) ^ 32'hFFFF);
    end
    vm = '1;
    rd(12'h140, r); chk("R5 running readback", r, 32'(vm));
    wr(win(3, 0), ad(3));
    chk("R3 new value at restart", cfg_xlen[3], xl(3) ^ 32'hFFFF);

    wr(12'h140, 32'h0005); vm &= ~NCH'(5);
    chk("R5 stop selected", 32'(ch_valid), 32'(vm));

    // Interrupt enable set and clear
    em = '0;
    wr(12'h148, 32'h00F0); em |= NCH'(16'h00F0);
    wr(12'h148, 32'h0100); em |= NCH'(16'h0100);
    rd(12'h148, r); chk("R8 enable set ORs", r, 32'(em));
    wr(12'h14C, 32'h0030); em &= ~NCH'(16'h0030);
    rd(12'h148, r); chk("R8 enable clear", r, 32'(em));
    rd(12'h14C, r); chk("R8 clear addr reads zero", r, 0);

    // Event sweep
    sm = '0;
    for (int n = 0; n < NCH; n++) begin
      pulse(NCH'(1) << n);
      sm |= NCH'(1) << n; vm &= ~(NCH'(1) << n);
      chk("R6 valid cleared by event", 32'(ch_valid), 32'(vm));
      chk("R9 irq", 32'(irq), 32'(|(sm & em)));
    end
    rd(12'h144, r); chk("R6 status all set", r, 32'(sm));
    wr(12'h144, 32'h0080); sm &= ~NCH'(16'h0080);
    rd(12'h144, r); chk("R7 single clear", r, 32'(sm));
    // Event and clear on the same edge
    @(negedge clk); bus_wr = 1'b1; bus_addr = 12'h144; bus_wdata = 32'h0004; ch_done = NCH'(4);
    @(negedge clk); bus_wr = 1'b0; ch_done = '0;
    rd(12'h144, r); chk("R7 event beats clear", r, 32'(sm));
    wr(12'h144, 32'hFFFF); sm = '0;
    chk("R9 irq after clear all", 32'(irq), 0);

    // Loop control on channel 5
    wr(win(5, 0), ad(5)); vm |= NCH'(16'h0020);
    wr(12'h150, (32'(1) << 5) | (32'(1) << 21));
    chk("R10 loop on", 32'(loop_on), 32'h20);
    wr(12'h150, 32'(1) << 6);
    chk("R10 half pair no loop", 32'(loop_on), 32'h20);
    pulse(NCH'(16'h0020));
    chk("R6 looping stays valid", 32'(ch_valid), 32'(vm));
    rd(12'h144, r); chk("R6 loop event status", r, 32'h20);
    wr(12'h154, 32'(1) << 21);
    chk("R10 pause", 32'(loop_on), 0);
    rd(12'h150, r); chk("R10 loop readback", r, 32'h60);
    rd(12'h154, r); chk("R10 clear addr reads zero", r, 0);
    wr(12'h150, 32'(1) << 21);
    chk("R10 resume", 32'(loop_on), 32'h20);
    wr(12'h154, 32'hFFFF_FFFF);
    pulse(NCH'(16'h0020)); vm &= ~NCH'(16'h0020);
    chk("R6 non-loop ends", 32'(ch_valid), 32'(vm));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule